// File: doc/BRIEF.md
# ECC Initialization and Scrub Engine

This block runs in the background beside a memory controller and keeps the stored check bits sound. Once ECC is switched on after reset, it first sweeps the configured address range. It writes an all-zero word with its matching check byte into every location, then raises a done flag. After that it reads one location at a time in rising address order and wraps back to zero at the end. Reads are spaced by a programmable pause. Every word read is decoded with a (72,64) extended Hamming SECDED code. A word with a single flipped bit is written back corrected, with fresh check bits, before the next address is read. A word with two flipped bits is only reported.

Requests leave on a valid/ready channel: command, address, write data and check byte. When `req_valid` is high and `req_ready` is low, the engine holds every request field steady until the handshake completes. Read data returns on a second valid/ready channel. `rsp_ready` is high only while the engine waits for its single outstanding read. The memory may hold `rsp_valid` high for as long as it needs. Separate saturating counters and last-address registers record corrected and uncorrectable events. Software clears each set with a one-cycle clear pulse.

Top module: `ecc_scrub_engine`

## Requirements
- R1: While `cfg_ecc_en` is low, the engine starts no new request. After reset with ECC disabled, `req_valid` stays low and `init_done` stays 0. If ECC is disabled later, the engine falls silent once its current transfer finishes.
- R2: Initialization writes each location from 0 to the last address exactly once, in ascending order. Every write carries data 0 and check byte 8'h00. `init_done` rises when the last write is accepted and never falls again outside reset.
- R3: A sweep-width setting of 0, or any setting above `ADDR_W_MAX`, covers 2^`ADDR_W_MAX` locations. Any other setting n covers locations 0 to 2^n-1, and no location above that range is written.
- R4: Between the completion of one scrub step and the next scrub read request, the engine presents no request for exactly max(`cfg_period`,1) × 2^`UNIT_LG` clock cycles.
- R5: Scrub reads visit addresses in ascending order and wrap from the last address of the range back to 0.
- R6: A single-bit error, in a data bit or in a check bit, causes a write to the same address with the corrected data and its recomputed check byte. This write comes before the next read. `ce_count` increments and `ce_addr` takes that address.
- R7: A double-bit error causes no write-back. `ue_count` increments and `ue_addr` takes that address.
- R8: Each error counter stops at 2^`CNT_W`-1 and holds there when further events arrive.
- R9: A one-cycle pulse on `clr_ce` or `clr_ue` zeroes the matching counter and address register on the next cycle. An event in the same cycle is counted as 1.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr`, `req_wdata` and `req_wcheck` keep their values on the next cycle.
- R11: While `cfg_scrub_en` is low, no scrub read is issued. Initialization is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | Master enable; the engine stays idle while low |
| cfg_scrub_en | input | 1 | Allows scrub reads once initialization is done |
| cfg_addr_bits | input | clog2(ADDR_W_MAX+1) | Sweep width in address bits; 0 means full width |
| cfg_period | input | PERIOD_W | Scrub pause in units of 2^UNIT_LG cycles; 0 acts as 1 |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W_MAX | Word address |
| req_wdata | output | 64 | Write data |
| req_wcheck | output | 8 | Write check byte |
| rsp_valid | input | 1 | Read data present |
| rsp_ready | output | 1 | Engine accepts read data |
| rsp_rdata | input | 64 | Read data word |
| rsp_rcheck | input | 8 | Read check byte |
| init_done | output | 1 | Initialization sweep finished |
| ce_count | output | CNT_W | Saturating corrected-error count |
| ce_addr | output | ADDR_W_MAX | Address of latest corrected error |
| ue_count | output | CNT_W | Saturating uncorrectable-error count |
| ue_addr | output | ADDR_W_MAX | Address of latest uncorrectable error |
| clr_ce | input | 1 | Clear pulse for the corrected-error status |
| clr_ue | input | 1 | Clear pulse for the uncorrectable-error status |

## Verification
The bench builds the engine with `ADDR_W_MAX`=4, `UNIT_LG`=2, `PERIOD_W`=4 and `CNT_W`=3. With a 16-word memory and a 3-bit sweep setting, both range cases and the wrap can be observed within a few hundred cycles. With a pause unit of 4 cycles, the exact gap can be measured for period 3 (12 cycles) and for period 0 (4 cycles). With 3-bit counters, a double-bit error left in memory saturates `ue_count` after seven passes.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  localparam int DATA_W  = 64;
  localparam int CHECK_W = 8;
  localparam int CW_LAST = 71;  // highest Hamming position

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_WAIT,
    ST_RD,
    ST_RSP,
    ST_FIX
  } scrub_st_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ce;
    logic              ue;
  } secded_res_t;

  // Check byte: bits 6:0 are Hamming parities at positions 1,2,4..64,
  // bit 7 is the overall parity over data and the seven parities.
  function automatic logic [CHECK_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CW_LAST:1]  cw;
    logic [CHECK_W-1:0] c;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int i = 0; i < CHECK_W - 1; i++)
      for (int p = 1; p <= CW_LAST; p++)
        if (p[i]) c[i] = c[i] ^ cw[p];
    c[CHECK_W-1] = (^d) ^ (^c[CHECK_W-2:0]);
    return c;
  endfunction

  function automatic secded_res_t secded_dec(input logic [DATA_W-1:0] d,
                                             input logic [CHECK_W-1:0] c);
    logic [CW_LAST:1] cw;
    logic [6:0]       syn;
    logic             ov;
    secded_res_t      r;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < CHECK_W - 1; i++) cw[1 << i] = c[i];
    syn = '0;
    for (int i = 0; i < CHECK_W - 1; i++)
      for (int p = 1; p <= CW_LAST; p++)
        if (p[i]) syn[i] = syn[i] ^ cw[p];
    ov   = (^d) ^ (^c);
    r.ce = 1'b0;
    r.ue = 1'b0;
    if (ov) begin
      if (syn == '0) begin
        r.ce = 1'b1;  // overall parity bit itself flipped
      end else if (int'(syn) <= CW_LAST) begin
        cw[syn] = ~cw[syn];
        r.ce    = 1'b1;
      end else begin
        r.ue = 1'b1;
      end
    end else if (syn != '0) begin
      r.ue = 1'b1;
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[k] = cw[p];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int PERIOD_W = 8,
  parameter int UNIT_LG  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  localparam int SPAN_W = PERIOD_W + UNIT_LG;

  logic [PERIOD_W-1:0] per_eff;
  logic [SPAN_W-1:0]   span_m1;
  logic [SPAN_W-1:0]   cnt;

  assign per_eff = (period == '0) ? PERIOD_W'(1) : period;
  assign span_m1 = (SPAN_W'(per_eff) << UNIT_LG) - SPAN_W'(1);
  assign tick    = run && (cnt == span_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + SPAN_W'(1);
  end

  // R4
  pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run));

endmodule

// File: rtl/scrub_status.sv
module scrub_status #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] where
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      where <= '0;
    end else if (clr) begin
      count <= ev ? CNT_W'(1) : '0;
      where <= ev ? ev_addr : '0;
    end else if (ev) begin
      if (count != CNT_MAX) count <= count + CNT_W'(1);
      where <= ev_addr;
    end
  end

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> (count == '0 && where == '0));

endmodule

// File: rtl/ecc_scrub_engine.sv
module ecc_scrub_engine
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W_MAX = 16,
  parameter int PERIOD_W   = 8,
  parameter int UNIT_LG    = 8,
  parameter int CNT_W      = 16,
  localparam int BITS_W    = $clog2(ADDR_W_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_ecc_en,
  input  logic                  cfg_scrub_en,
  input  logic [BITS_W-1:0]     cfg_addr_bits,
  input  logic [PERIOD_W-1:0]   cfg_period,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic                  req_write,
  output logic [ADDR_W_MAX-1:0] req_addr,
  output logic [DATA_W-1:0]     req_wdata,
  output logic [CHECK_W-1:0]    req_wcheck,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [DATA_W-1:0]     rsp_rdata,
  input  logic [CHECK_W-1:0]    rsp_rcheck,
  output logic                  init_done,
  output logic [CNT_W-1:0]      ce_count,
  output logic [ADDR_W_MAX-1:0] ce_addr,
  output logic [CNT_W-1:0]      ue_count,
  output logic [ADDR_W_MAX-1:0] ue_addr,
  input  logic                  clr_ce,
  input  logic                  clr_ue
);
  localparam logic [CHECK_W-1:0] ZERO_CHK = secded_enc('0);

  scrub_st_t             state;
  logic [ADDR_W_MAX-1:0] cur_addr, last_addr, next_addr;
  logic [DATA_W-1:0]     fix_data;
  logic [CHECK_W-1:0]    fix_check;
  int                    sweep_bits;
  logic                  req_fire, rsp_fire, pace_run, pace_tick;
  logic                  ce_ev, ue_ev;
  secded_res_t           dec;

  // Sweep range from the address-bit setting
  always_comb begin
    if (cfg_addr_bits == '0 || int'(cfg_addr_bits) > ADDR_W_MAX)
      sweep_bits = ADDR_W_MAX;
    else
      sweep_bits = int'(cfg_addr_bits);
    last_addr = {ADDR_W_MAX{1'b1}} >> (ADDR_W_MAX - sweep_bits);
  end

  assign next_addr  = (cur_addr >= last_addr) ? '0 : cur_addr + ADDR_W_MAX'(1);

  assign req_valid  = (state == ST_INIT) || (state == ST_RD) || (state == ST_FIX);
  assign req_write  = (state == ST_INIT) || (state == ST_FIX);
  assign req_addr   = cur_addr;
  assign req_wdata  = (state == ST_FIX) ? fix_data  : '0;
  assign req_wcheck = (state == ST_FIX) ? fix_check : ZERO_CHK;
  assign rsp_ready  = (state == ST_RSP);
  assign req_fire   = req_valid && req_ready;
  assign rsp_fire   = rsp_valid && rsp_ready;

  assign dec      = secded_dec(rsp_rdata, rsp_rcheck);
  assign ce_ev    = rsp_fire && dec.ce;
  assign ue_ev    = rsp_fire && dec.ue;
  assign pace_run = (state == ST_WAIT) && cfg_ecc_en && cfg_scrub_en;

  scrub_pacer #(.PERIOD_W(PERIOD_W), .UNIT_LG(UNIT_LG)) pacer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (pace_run),
    .period (cfg_period),
    .tick   (pace_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      init_done <= 1'b0;
      fix_data  <= '0;
      fix_check <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cfg_ecc_en) state <= init_done ? ST_WAIT : ST_INIT;
        ST_INIT: if (req_fire) begin
          cur_addr <= next_addr;
          if (cur_addr >= last_addr) begin
            init_done <= 1'b1;
            state     <= cfg_ecc_en ? ST_WAIT : ST_IDLE;
          end else if (!cfg_ecc_en) begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (!cfg_ecc_en)    state <= ST_IDLE;
          else if (pace_tick) state <= ST_RD;
        end
        ST_RD: if (req_fire) state <= ST_RSP;
        ST_RSP: if (rsp_fire) begin
          if (dec.ce) begin
            fix_data  <= dec.data;
            fix_check <= secded_enc(dec.data);
            state     <= ST_FIX;
          end else begin
            cur_addr <= next_addr;
            state    <= ST_WAIT;
          end
        end
        ST_FIX: if (req_fire) begin
          cur_addr <= next_addr;
          state    <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  scrub_status #(.ADDR_W(ADDR_W_MAX), .CNT_W(CNT_W)) ce_stat_i (
    .clk(clk), .rst_n(rst_n), .ev(ce_ev), .ev_addr(cur_addr),
    .clr(clr_ce), .count(ce_count), .where(ce_addr)
  );

  scrub_status #(.ADDR_W(ADDR_W_MAX), .CNT_W(CNT_W)) ue_stat_i (
    .clk(clk), .rst_n(rst_n), .ev(ue_ev), .ev_addr(cur_addr),
    .clr(clr_ue), .count(ue_count), .where(ue_addr)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
      $stable(req_addr) && $stable(req_wdata) && $stable(req_wcheck)));

  // R1 R11
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_write) |-> $past(cfg_ecc_en && cfg_scrub_en));

  // R6
  fix_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_ev |=> (req_valid && req_write && req_addr == $past(cur_addr)));

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  ue_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_ev |=> !req_valid);

endmodule

// File: tb/ecc_scrub_engine_tb_top.sv
`timescale 1ns/1ps
module ecc_scrub_engine_tb_top;
  localparam int AW = 4;
  localparam int PW = 4;
  localparam int UL = 2;
  localparam int CW = 3;
  localparam int BW = 3;
  localparam int LOG_N = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_ecc_en = 1'b0, cfg_scrub_en = 1'b0;
  logic [BW-1:0] cfg_addr_bits = 3'd3;
  logic [PW-1:0] cfg_period = 4'd3;
  logic          req_valid, req_ready = 1'b1, req_write;
  logic [AW-1:0] req_addr;
  logic [63:0]   req_wdata;
  logic [7:0]    req_wcheck;
  logic          rsp_valid, rsp_ready;
  logic [63:0]   rsp_rdata;
  logic [7:0]    rsp_rcheck;
  logic          init_done;
  logic [CW-1:0] ce_count, ue_count;
  logic [AW-1:0] ce_addr, ue_addr;
  logic          clr_ce = 1'b0, clr_ue = 1'b0;

  ecc_scrub_engine #(.ADDR_W_MAX(AW), .PERIOD_W(PW), .UNIT_LG(UL), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_scrub_en(cfg_scrub_en),
    .cfg_addr_bits(cfg_addr_bits), .cfg_period(cfg_period),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wcheck(req_wcheck),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_rcheck(rsp_rcheck), .init_done(init_done),
    .ce_count(ce_count), .ce_addr(ce_addr), .ue_count(ue_count), .ue_addr(ue_addr),
    .clr_ce(clr_ce), .clr_ue(clr_ue)
  );

  // Memory model, event log and hold monitor
  logic [63:0] mdata [16];
  logic [7:0]  mchk  [16];
  int          ev_kind [LOG_N];  // 0 read, 1 write, 2 read data taken
  logic [AW-1:0] ev_addr [LOG_N];
  logic [63:0] ev_data [LOG_N];
  logic [7:0]  ev_chk  [LOG_N];
  int          ev_cyc  [LOG_N];
  int          ev_n = 0, cyc = 0, rd_count = 0, stall_seen = 0, hold_err = 0;
  logic [AW-1:0] last_rd_addr;
  logic        held = 1'b0;
  logic [76:0] hold_val;
  logic        inj = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [63:0] inj_dmask = '0;
  logic [7:0]  inj_cmask = '0;
  logic [AW-1:0] rsp_addr;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mdata[i] <= '0; mchk[i] <= '0; end
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_rcheck <= '0; rsp_addr <= '0;
      held <= 1'b0;
    end else begin
      if (inj) begin
        mdata[inj_addr] <= mdata[inj_addr] ^ inj_dmask;
        mchk[inj_addr]  <= mchk[inj_addr] ^ inj_cmask;
      end
      if (req_valid && req_ready) begin
        ev_kind[ev_n % LOG_N] <= req_write ? 1 : 0;
        ev_addr[ev_n % LOG_N] <= req_addr;
        ev_data[ev_n % LOG_N] <= req_wdata;
        ev_chk[ev_n % LOG_N]  <= req_wcheck;
        ev_cyc[ev_n % LOG_N]  <= cyc;
        ev_n <= ev_n + 1;
        if (req_write) begin
          mdata[req_addr] <= req_wdata;
          mchk[req_addr]  <= req_wcheck;
        end else begin
          rsp_valid <= 1'b1; rsp_rdata <= mdata[req_addr]; rsp_rcheck <= mchk[req_addr];
          rsp_addr <= req_addr; rd_count <= rd_count + 1; last_rd_addr <= req_addr;
        end
      end else if (rsp_valid && rsp_ready) begin
        ev_kind[ev_n % LOG_N] <= 2;
        ev_addr[ev_n % LOG_N] <= rsp_addr;
        ev_data[ev_n % LOG_N] <= '0;
        ev_chk[ev_n % LOG_N]  <= '0;
        ev_cyc[ev_n % LOG_N]  <= cyc;
        ev_n <= ev_n + 1;
        rsp_valid <= 1'b0;
      end
      if (held && !(req_valid && hold_val == {req_write, req_addr, req_wdata, req_wcheck}))
        hold_err <= hold_err + 1;
      held     <= req_valid && !req_ready;
      hold_val <= {req_write, req_addr, req_wdata, req_wcheck};
      if (req_valid && !req_ready) stall_seen <= stall_seen + 1;
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [63:0] dm, input logic [7:0] cm);
    @(negedge clk);
    inj = 1'b1; inj_addr = AW'(a); inj_dmask = dm; inj_cmask = cm;
    @(negedge clk);
    inj = 1'b0;
  endtask

  task automatic wait_rd(input int a);
    int c;
    c = rd_count;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (rd_count != c) begin
        if (int'(last_rd_addr) == a) return;
        c = rd_count;
      end
    end
    chk(1'b0, "wait_rd timeout", 64'(last_rd_addr), 64'(a));
  endtask

  task automatic wait_reads(input int n);
    int c;
    c = rd_count;
    for (int t = 0; t < 5000 && rd_count - c < n; t++) @(negedge clk);
  endtask

  // R1: no activity while disabled after reset
  task automatic t_reset_idle();
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, "R1 req_valid while disabled", 64'(seen), 0);
    chk(init_done == 1'b0, "R1 init_done after reset", 64'(init_done), 0);
    chk(ce_count == '0 && ue_count == '0 && ce_addr == '0 && ue_addr == '0,
        "R1 status after reset", 64'({ce_count, ue_count}), 0);
  endtask

  // R2 R3 R11: init sweep over 8 locations, scrub held off
  task automatic t_init();
    int s, nw, rd0;
    bit order_ok;
    for (int a = 0; a < 16; a++) poke(a, '1, '1);
    s = ev_n;
    cfg_ecc_en = 1'b1;
    for (int t = 0; t < 500 && !init_done; t++) @(negedge clk);
    chk(init_done == 1'b1, "R2 init_done raised", 64'(init_done), 1);
    nw = 0; order_ok = 1'b1;
    for (int i = s; i < ev_n; i++) begin
      if (ev_kind[i % LOG_N] != 1) order_ok = 1'b0;
      else begin
        if (int'(ev_addr[i % LOG_N]) != nw || ev_data[i % LOG_N] != '0 || ev_chk[i % LOG_N] != '0)
          order_ok = 1'b0;
        nw++;
      end
    end
    chk(nw == 8, "R2 R3 init write count for 3-bit range", 64'(nw), 8);
    chk(order_ok, "R2 init ascending zero writes", 64'(order_ok), 1);
    chk(mdata[8] == '1 && mdata[15] == '1, "R3 above range untouched", mdata[8], '1);
    rd0 = rd_count;
    repeat (100) @(negedge clk);
    chk(rd_count == rd0, "R11 no reads with scrub disabled", 64'(rd_count - rd0), 0);
  endtask

  // R4 R5: order, wrap and exact pause
  task automatic t_scrub_order();
    int s, k, ng;
    bit ok_seq, ok_gap;
    s = ev_n;
    cfg_scrub_en = 1'b1;
    wait_reads(10);
    k = 0; ok_seq = 1'b1; ok_gap = 1'b1; ng = 0;
    for (int i = s; i < ev_n; i++) begin
      if (ev_kind[i % LOG_N] == 0) begin
        if (int'(ev_addr[i % LOG_N]) != k % 8) ok_seq = 1'b0;
        k++;
        if (i > s && ev_kind[(i - 1) % LOG_N] == 2) begin
          ng++;
          if (ev_cyc[i % LOG_N] - ev_cyc[(i - 1) % LOG_N] != 13) ok_gap = 1'b0;
        end
      end
    end
    chk(k >= 10 && ok_seq, "R5 ascending reads with wrap", 64'(k), 10);
    chk(ng >= 5 && ok_gap, "R4 pause of 12 cycles at period 3", 64'(ng), 5);
    cfg_period = 4'd0;
    wait_reads(2);
    s = ev_n;
    wait_reads(4);
    ok_gap = 1'b1; ng = 0;
    for (int i = s + 1; i < ev_n; i++)
      if (ev_kind[i % LOG_N] == 0 && ev_kind[(i - 1) % LOG_N] == 2) begin
        ng++;
        if (ev_cyc[i % LOG_N] - ev_cyc[(i - 1) % LOG_N] != 5) ok_gap = 1'b0;
      end
    chk(ng >= 2 && ok_gap, "R4 period 0 acts as 1 (4 cycles)", 64'(ng), 2);
  endtask

  function automatic bit fix_seq_ok(input int s, input int a);
    for (int i = s; i + 3 < ev_n; i++)
      if (ev_kind[i % LOG_N] == 0 && int'(ev_addr[i % LOG_N]) == a)
        return ev_kind[(i + 1) % LOG_N] == 2 &&
               ev_kind[(i + 2) % LOG_N] == 1 && int'(ev_addr[(i + 2) % LOG_N]) == a &&
               ev_data[(i + 2) % LOG_N] == '0 && ev_chk[(i + 2) % LOG_N] == '0 &&
               ev_kind[(i + 3) % LOG_N] == 0 && int'(ev_addr[(i + 3) % LOG_N]) == (a + 1) % 8;
    return 1'b0;
  endfunction

  // R6: data-bit and check-bit single errors repaired in place
  task automatic t_correct();
    int s;
    wait_rd(7);
    s = ev_n;
    poke(5, 64'h1 << 17, 8'h00);
    poke(2, 64'h0, 8'h08);
    wait_rd(6);
    wait_reads(1);
    chk(fix_seq_ok(s, 2), "R6 check-bit error written back before next read", 0, 1);
    chk(fix_seq_ok(s, 5), "R6 data-bit error written back before next read", 0, 1);
    chk(ce_count == 3'd2, "R6 corrected count", 64'(ce_count), 2);
    chk(ce_addr == 4'd5, "R6 corrected address", 64'(ce_addr), 5);
    chk(mdata[5] == '0 && mchk[2] == '0, "R6 memory repaired", mdata[5], 0);
  endtask

  // R7 R8 R9: double error logged, saturation, clear pulses
  task automatic t_detect();
    int s;
    bit wrote3;
    wait_rd(4);
    poke(3, 64'h3, 8'h00);
    s = ev_n;
    wait_rd(4);
    chk(ue_count == 3'd1, "R7 uncorrectable count", 64'(ue_count), 1);
    chk(ue_addr == 4'd3, "R7 uncorrectable address", 64'(ue_addr), 3);
    wrote3 = 1'b0;
    for (int i = s; i < ev_n; i++)
      if (ev_kind[i % LOG_N] == 1 && ev_addr[i % LOG_N] == 4'd3) wrote3 = 1'b1;
    chk(!wrote3, "R7 no write-back on double error", 64'(wrote3), 0);
    for (int p = 0; p < 8; p++) wait_rd(4);
    chk(ue_count == 3'd7, "R8 counter holds at maximum", 64'(ue_count), 7);
    chk(ce_count == 3'd2, "R8 corrected count unchanged", 64'(ce_count), 2);
    wait_rd(5);
    clr_ue = 1'b1; clr_ce = 1'b1;
    @(negedge clk);
    clr_ue = 1'b0; clr_ce = 1'b0;
    chk(ue_count == '0 && ue_addr == '0, "R9 clear uncorrectable status",
        64'({ue_count, ue_addr}), 0);
    chk(ce_count == '0 && ce_addr == '0, "R9 clear corrected status",
        64'({ce_count, ce_addr}), 0);
    poke(3, 64'h3, 8'h00);
  endtask

  // R3 R10: full range with back-pressure
  task automatic t_full_bp();
    int s, st0, prev;
    bit ok_seq, saw_wrap;
    for (int a = 8; a < 16; a++) poke(a, '1, '1);
    @(negedge clk);
    cfg_addr_bits = 3'd0;
    s = ev_n; st0 = stall_seen;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      req_ready = !((i % 5 == 0) || (i % 7 == 3));
    end
    @(negedge clk);
    req_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(stall_seen > st0, "R10 stalls exercised", 64'(stall_seen - st0), 1);
    chk(hold_err == 0, "R10 request held while stalled", 64'(hold_err), 0);
    ok_seq = 1'b1; saw_wrap = 1'b0; prev = -1;
    for (int i = s; i < ev_n; i++)
      if (ev_kind[i % LOG_N] == 0) begin
        if (prev >= 0 && int'(ev_addr[i % LOG_N]) != (prev + 1) % 16) ok_seq = 1'b0;
        if (prev == 15 && ev_addr[i % LOG_N] == 4'd0) saw_wrap = 1'b1;
        prev = int'(ev_addr[i % LOG_N]);
      end
    chk(ok_seq && saw_wrap, "R3 setting 0 sweeps all 16 words", 64'(prev), 15);
  endtask

  // R1: disable after running
  task automatic t_disable();
    bit seen;
    cfg_ecc_en = 1'b0;
    repeat (30) @(negedge clk);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, "R1 silent after disable", 64'(seen), 0);
    chk(init_done == 1'b1, "R2 init_done stays high", 64'(init_done), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_init();
    t_scrub_order();
    t_correct();
    t_detect();
    t_full_bp();
    t_disable();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule